// File: doc/BRIEF.md
# LCD Common Scan and Blink Timing Generator

This block sets the row timing for a dot-matrix LCD with up to 73 common (row) electrodes. A prescaler divides the system clock into line periods. A row counter steps through the active rows and drives a one-hot common select. It also brings out the row index, a one-clock strobe that tells the segment path to latch the next line, and a frame toggle that inverts once per frame. The number of scanned rows is picked by a 2-bit duty code. A change of that code waits for the next frame boundary, so a frame is never cut short.

Two controllers can drive one panel. The master drives a sync line with a pulse one line wide whenever its frame wraps. A slave listens to that line through a two-flop synchronizer. On each rising edge it restarts at row 0. If the master is late, the slave waits on its last row instead of wrapping on its own. Apart from the scan, a slow external square wave of about 2 Hz is halved into a blink phase of about 1 Hz.

The nominal reference clock is about 4.19 MHz. The line period is the parameter `LINE_CLKS`, counted in clock cycles.

Top module: `lcd_com_scan`

## Requirements
- R1: The duty code selects the row count N: 2'b00 gives 35, 2'b01 gives 37, 2'b10 gives 71 and 2'b11 gives 73. `row_idx` counts 0, 1, …, N−1 and then wraps to 0.
- R2: After reset, `com_sel` is one-hot, and its set bit is the bit numbered `row_idx`. A common at or above N is never selected.
- R3: In master mode every row lasts exactly `LINE_CLKS` clock cycles. `line_strobe` is high for exactly the first cycle of every row that is entered by an advance, a wrap or a resync.
- R4: `frame_flag` inverts in the same cycle in which `row_idx` wraps to 0, and at no other time.
- R5: A new duty code is taken up only at a frame boundary, which is a wrap or a slave resync. The frame in progress ends at the row count that was active when it began. After reset the active row count is 35.
- R6: In master mode `sync_oe` is 1, and `sync_out` is high for exactly the one line period of row 0 that follows each wrap. It is not high in the first frame after reset.
- R7: In slave mode `sync_oe` and `sync_out` are 0. A rising edge on `sync_in`, seen after a two-flop synchronizer, forces row 0, restarts the line prescaler, pulses `line_strobe`, inverts `frame_flag` and loads the duty code. Without such an edge the slave holds at row N−1 and does not wrap.
- R8: Each rising edge of `blink_clk` inverts `blink_phase`, after a two-flop synchronizer. Falling edges have no effect, so `blink_phase` runs at half the input frequency.
- R9: While `rst_n` is low, `com_sel` is all zero, and `row_idx`, `line_strobe`, `frame_flag`, `sync_out` and `blink_phase` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_sel | input | 2 | Duty code (R1 encoding) |
| blink_clk | input | 1 | Slow external blink clock, about 2 Hz |
| slave_mode | input | 1 | 1 = follow `sync_in`, 0 = master |
| sync_in | input | 1 | Level sensed on the shared sync line |
| sync_out | output | 1 | Frame sync pulse driven in master mode |
| sync_oe | output | 1 | Output enable for the sync line driver |
| com_sel | output | COM_COUNT | One-hot common select |
| row_idx | output | ROW_W | Current row index |
| line_strobe | output | 1 | One-cycle strobe at the start of each row |
| frame_flag | output | 1 | Inverts once per frame |
| blink_phase | output | 1 | Halved blink clock |

## Verification
The bench runs every duty code. It changes the code in the middle of a frame and checks that the frame in progress still ends on the old last row. A design that applies the code at once would end that frame early or run past it. Each frame's length in cycles, its strobe count and its sync-pulse width are measured against N and `LINE_CLKS`. An off-by-one wrap, a strobe two cycles wide or a sync pulse that spans two rows each change one of those totals. In slave mode the bench lets the counter run out to confirm that it holds on the last row rather than wrapping. It then resyncs both at the hold and in the middle of a frame, and checks that the prescaler restarts and that the duty code loaded at the resync sets where the counter next holds. Blink checks confirm that only rising edges count. A design that toggles on both edges would double the blink rate.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    DUTY_35 = 2'b00,
    DUTY_37 = 2'b01,
    DUTY_71 = 2'b10,
    DUTY_73 = 2'b11
  } duty_code_e;

  // Number of scanned rows for each duty code.
  function automatic int duty_rows(duty_code_e code);
    case (code)
      DUTY_35: return 35;
      DUTY_37: return 37;
      DUTY_71: return 71;
      default: return 73;
    endcase
  endfunction

endpackage

// File: rtl/lcd_edge_sync.sv
// Multi-stage synchronizer with rising-edge detect on the synchronized level.
module lcd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], d};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/lcd_line_prescaler.sv
// Divides the clock into line periods of LINE_CLKS cycles.
module lcd_line_prescaler #(
  parameter int LINE_CLKS = 16,
  localparam int CW = (LINE_CLKS > 2) ? $clog2(LINE_CLKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic line_end
);
  localparam logic [CW-1:0] LAST = CW'(LINE_CLKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (restart)      cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + CW'(1);
  end

  assign line_end = (cnt == LAST);
endmodule

// File: rtl/lcd_row_sequencer.sv
// Row counter with frame-boundary duty latching, master sync pulse
// generation and slave resync handling.
module lcd_row_sequencer
  import lcd_scan_pkg::*;
#(
  parameter int ROW_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_end,
  input  logic             resync,
  input  logic             slave_mode,
  input  duty_code_e       duty_sel,
  output logic [ROW_W-1:0] row_idx,
  output logic             line_strobe,
  output logic             frame_flag,
  output logic             sync_pulse
);
  duty_code_e       duty_act;
  logic [ROW_W-1:0] last_row;
  logic             at_last;

  assign last_row = ROW_W'(duty_rows(duty_act) - 1);
  assign at_last  = (row_idx == last_row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_idx     <= '0;
      line_strobe <= 1'b0;
      frame_flag  <= 1'b0;
      sync_pulse  <= 1'b0;
      duty_act    <= DUTY_35;
    end else if (resync) begin
      // Slave frame start forced by the master.
      row_idx     <= '0;
      line_strobe <= 1'b1;
      frame_flag  <= ~frame_flag;
      sync_pulse  <= 1'b0;
      duty_act    <= duty_sel;
    end else if (line_end && at_last) begin
      if (!slave_mode) begin
        row_idx     <= '0;
        line_strobe <= 1'b1;
        frame_flag  <= ~frame_flag;
        sync_pulse  <= 1'b1;
        duty_act    <= duty_sel;
      end else begin
        // Slave waits on its last row for the master.
        line_strobe <= 1'b0;
      end
    end else if (line_end) begin
      row_idx     <= row_idx + ROW_W'(1);
      line_strobe <= 1'b1;
      sync_pulse  <= 1'b0;
    end else begin
      line_strobe <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_com_decoder.sv
// One-hot common select, held at non-select until the first clock after reset.
module lcd_com_decoder #(
  parameter int COM_COUNT = 73,
  parameter int ROW_W     = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROW_W-1:0]     row_idx,
  output logic [COM_COUNT-1:0] com_sel
);
  logic scan_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scan_en <= 1'b0;
    else        scan_en <= 1'b1;
  end

  for (genvar i = 0; i < COM_COUNT; i++) begin : g_com
    assign com_sel[i] = scan_en & (row_idx == ROW_W'(i));
  end
endmodule

// File: rtl/lcd_blink_div.sv
// Halves the external blink clock on its synchronized rising edges.
module lcd_blink_div #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blink_clk,
  output logic blink_phase
);
  logic blink_rise;

  lcd_edge_sync #(.STAGES(SYNC_STAGES)) u_blink_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (blink_clk),
    .rise (blink_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          blink_phase <= 1'b0;
    else if (blink_rise) blink_phase <= ~blink_phase;
  end
endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan
  import lcd_scan_pkg::*;
#(
  parameter int COM_COUNT   = 73,
  parameter int LINE_CLKS   = 16,
  parameter int SYNC_STAGES = 2,
  localparam int ROW_W      = $clog2(COM_COUNT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           duty_sel,
  input  logic                 blink_clk,
  input  logic                 slave_mode,
  input  logic                 sync_in,
  output logic                 sync_out,
  output logic                 sync_oe,
  output logic [COM_COUNT-1:0] com_sel,
  output logic [ROW_W-1:0]     row_idx,
  output logic                 line_strobe,
  output logic                 frame_flag,
  output logic                 blink_phase
);
  logic sync_rise;
  logic resync;
  logic line_end;
  logic sync_pulse;

  lcd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_in (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (sync_in),
    .rise (sync_rise)
  );

  assign resync = slave_mode & sync_rise;

  lcd_line_prescaler #(.LINE_CLKS(LINE_CLKS)) u_prescaler (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (resync),
    .line_end(line_end)
  );

  lcd_row_sequencer #(.ROW_W(ROW_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_end   (line_end),
    .resync     (resync),
    .slave_mode (slave_mode),
    .duty_sel   (duty_code_e'(duty_sel)),
    .row_idx    (row_idx),
    .line_strobe(line_strobe),
    .frame_flag (frame_flag),
    .sync_pulse (sync_pulse)
  );

  lcd_com_decoder #(.COM_COUNT(COM_COUNT), .ROW_W(ROW_W)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .row_idx(row_idx),
    .com_sel(com_sel)
  );

  lcd_blink_div #(.SYNC_STAGES(SYNC_STAGES)) u_blink (
    .clk        (clk),
    .rst_n      (rst_n),
    .blink_clk  (blink_clk),
    .blink_phase(blink_phase)
  );

  assign sync_oe  = ~slave_mode;
  assign sync_out = sync_pulse & ~slave_mode;
endmodule

// File: rtl/lcd_com_scan_chk.sv
module lcd_com_scan_chk #(
  parameter int COM_COUNT = 73,
  parameter int ROW_W     = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 slave_mode,
  input logic                 sync_out,
  input logic                 sync_oe,
  input logic [COM_COUNT-1:0] com_sel,
  input logic [ROW_W-1:0]     row_idx,
  input logic                 line_strobe,
  input logic                 frame_flag
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_sel));

  p_sel_matches_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (com_sel != '0) |-> com_sel[row_idx]);

  p_row_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    row_idx < ROW_W'(COM_COUNT));

  p_row_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_strobe |-> (row_idx == '0 || row_idx == $past(row_idx) + ROW_W'(1)));

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_strobe |=> !line_strobe);

  p_row_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !line_strobe |-> $stable(row_idx));

  p_frame_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_flag != $past(frame_flag)) |-> (line_strobe && row_idx == '0));

  p_sync_row0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> (row_idx == '0));

  p_slave_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (!sync_oe && !sync_out));
endmodule

bind lcd_com_scan lcd_com_scan_chk #(.COM_COUNT(COM_COUNT), .ROW_W(ROW_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slave_mode (slave_mode),
  .sync_out   (sync_out),
  .sync_oe    (sync_oe),
  .com_sel    (com_sel),
  .row_idx    (row_idx),
  .line_strobe(line_strobe),
  .frame_flag (frame_flag)
);

// File: tb/lcd_com_scan_bench.sv
`timescale 1ns/1ps
module lcd_com_scan_bench;
  localparam int COM_COUNT = 73;
  localparam int LINE_CLKS = 4;
  localparam int ROW_W     = 7;
  localparam int NVEC      = 5;

  // Stimulus table: duty code and the row count it must give (R1).
  localparam logic [1:0] VEC_CODE [0:NVEC-1] = '{2'd3, 2'd0, 2'd2, 2'd1, 2'd3};
  localparam int         VEC_ROWS [0:NVEC-1] = '{73, 35, 71, 37, 73};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] duty_sel = 2'd0;
  logic blink_clk = 1'b0;
  logic slave_mode = 1'b0;
  logic sync_in = 1'b0;
  logic sync_out, sync_oe, line_strobe, frame_flag, blink_phase;
  logic [COM_COUNT-1:0] com_sel;
  logic [ROW_W-1:0] row_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lcd_com_scan #(.COM_COUNT(COM_COUNT), .LINE_CLKS(LINE_CLKS)) u_lcd_com_scan (
    .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .blink_clk(blink_clk),
    .slave_mode(slave_mode), .sync_in(sync_in), .sync_out(sync_out),
    .sync_oe(sync_oe), .com_sel(com_sel), .row_idx(row_idx),
    .line_strobe(line_strobe), .frame_flag(frame_flag), .blink_phase(blink_phase)
  );

  task automatic check_eq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit sel_ok();
    return (com_sel == (COM_COUNT'(1) << row_idx));
  endfunction

  // Run until frame_flag inverts; report the row seen just before it.
  task automatic wait_toggle(output int last_row);
    logic f;
    f = frame_flag;
    last_row = row_idx;
    for (int k = 0; k < 2000 && frame_flag == f; k++) begin
      last_row = row_idx;
      @(negedge clk);
    end
  endtask

  // Called in the toggle cycle; returns in the next toggle cycle.
  task automatic measure_frame(output int cyc, output int strobes,
                               output int maxrow, output int syncc, output int badsel);
    logic f;
    f = frame_flag;
    cyc = 1; strobes = int'(line_strobe); maxrow = row_idx;
    syncc = int'(sync_out); badsel = sel_ok() ? 0 : 1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (frame_flag != f) break;
      cyc++;
      strobes += int'(line_strobe);
      syncc   += int'(sync_out);
      if (int'(row_idx) > maxrow) maxrow = row_idx;
      if (!sel_ok()) badsel++;
    end
  endtask

  task automatic reset_checks(string tag);
    check_eq("R9", {tag, " com_sel ones"}, $countones(com_sel), 0);
    check_eq("R9", {tag, " row_idx"}, row_idx, 0);
    check_eq("R9", {tag, " line_strobe"}, line_strobe, 0);
    check_eq("R9", {tag, " frame_flag"}, frame_flag, 0);
    check_eq("R9", {tag, " sync_out"}, sync_out, 0);
    check_eq("R9", {tag, " blink_phase"}, blink_phase, 0);
  endtask

  // Wait for a strobe on row 0 (resync) within a short window.
  task automatic wait_resync(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (line_strobe && row_idx == '0) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  initial begin
    int last_row, cyc, strobes, maxrow, syncc, badsel, prev_rows;
    logic f;
    bit seen;

    tick(3);
    reset_checks("in reset");
    rst_n = 1'b1;
    tick(1);
    check_eq("R2", "first select after reset", sel_ok(), 1);
    check_eq("R6", "no sync in first frame", sync_out, 0);
    check_eq("R6", "master sync_oe", sync_oe, 1);

    // Table walk: change the duty mid-frame, then measure the next frame.
    prev_rows = 35;  // R5: active count after reset
    for (int i = 0; i < NVEC; i++) begin
      tick(LINE_CLKS * 3);
      duty_sel = VEC_CODE[i];
      wait_toggle(last_row);
      check_eq("R5", $sformatf("vec%0d old frame last row", i), last_row, prev_rows - 1);
      check_eq("R4", $sformatf("vec%0d wrap row/strobe", i),
               {line_strobe, 7'(row_idx)}, {1'b1, 7'd0});
      measure_frame(cyc, strobes, maxrow, syncc, badsel);
      check_eq("R1", $sformatf("vec%0d strobes per frame", i), strobes, VEC_ROWS[i]);
      check_eq("R1", $sformatf("vec%0d highest row", i), maxrow, VEC_ROWS[i] - 1);
      check_eq("R3", $sformatf("vec%0d cycles per frame", i), cyc, VEC_ROWS[i] * LINE_CLKS);
      check_eq("R6", $sformatf("vec%0d sync width", i), syncc, LINE_CLKS);
      check_eq("R2", $sformatf("vec%0d bad selects", i), badsel, 0);
      prev_rows = VEC_ROWS[i];
    end

    // Blink: only rising edges count (R8).
    f = blink_phase;
    blink_clk = 1'b1; tick(5);
    check_eq("R8", "first rise toggles", blink_phase, !f);
    blink_clk = 1'b0; tick(5);
    check_eq("R8", "fall ignored", blink_phase, !f);
    blink_clk = 1'b1; tick(5);
    check_eq("R8", "second rise toggles back", blink_phase, f);
    blink_clk = 1'b0; tick(2);

    // Slave: release line, park at last row (duty 73 active), then resync.
    slave_mode = 1'b1;
    tick(1);
    check_eq("R7", "slave sync_oe", sync_oe, 0);
    check_eq("R7", "slave sync_out", sync_out, 0);
    f = frame_flag;
    tick(73 * LINE_CLKS + 20);
    check_eq("R7", "slave parks on last row", row_idx, 72);
    check_eq("R7", "no self wrap in slave", frame_flag, f);
    check_eq("R2", "select on parked row", sel_ok(), 1);

    duty_sel = 2'd0;
    sync_in = 1'b1;
    wait_resync(seen);
    check_eq("R7", "resync at park", seen, 1);
    check_eq("R7", "frame toggled on resync", frame_flag, !f);
    tick(LINE_CLKS * 3);
    check_eq("R7", "prescaler restarted by resync", row_idx, 3);
    sync_in = 1'b0;
    tick(35 * LINE_CLKS + 20);
    check_eq("R5", "duty loaded at resync parks at 34", row_idx, 34);

    // Mid-frame resync.
    duty_sel = 2'd3;
    tick(3);
    sync_in = 1'b1;
    wait_resync(seen);
    check_eq("R7", "resync at park with new duty", seen, 1);
    sync_in = 1'b0;
    tick(LINE_CLKS * 5 + 1);
    sync_in = 1'b1;
    wait_resync(seen);
    check_eq("R7", "mid-frame resync", seen, 1);
    sync_in = 1'b0;

    // Reset in the middle of a run.
    tick(LINE_CLKS * 2 + 1);
    rst_n = 1'b0;
    tick(1);
    reset_checks("mid-run reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule